// File: doc/BRIEF.md
# Dual-Line Sampling Converter Serial Port Emulator

This block stands in for the device side of a two-channel sampling converter's serial port, so that host-side serial controllers can be tested in loopback against synthesizable logic. The host drives an active-low chip select and a serial clock. The block latches two 12-bit sample words, one per channel, at the instant chip select falls. It then shifts the two results out, MSB first, on two data lines. Each line has its own output enable, which models a three-state pin.

Chip select, the serial clock and the two sample words are sampled by a fast system clock. They are assumed to be synchronous to it: a host in the same clock domain, or a testbench. Each result is framed as two leading zeros, the twelve data bits and two trailing zeros, giving 16 serial clocks per line. A host that keeps chip select low past the 16th clock receives the second channel's frame on line A. This lets one data line carry both results in 32 clocks. Conversion timing, analog behaviour and power modes are not modelled.

Top module: `adcDualPortEmu`

## Requirements
- R1: While reset is asserted and after it is released, both enables are low and both data lines read 0 until chip select is next seen falling.
- R2: One clk edge after chip select is seen falling, both sample words are held, both enables are high, and both lines show the first leading zero.
- R3: Each serial-clock falling edge seen while chip select is low advances both lines by one bit. The sequence is the second leading zero, then data bits 11 down to 0, most significant first.
- R4: After falls 14 and 15 both lines show 0, the trailing zeros. After fall 16, line B's enable goes low.
- R5: If chip select stays low, line A shows two zeros, sample word B bits 11 down to 0, and two zeros after falls 16 to 31. After fall 32, line A's enable goes low, and later falls change nothing.
- R6: A serial-clock fall seen in the same clk cycle as the chip-select fall is not counted. The next fall advances the lines to the second leading zero.
- R7: A chip-select rise at any frame position drops both enables one clk edge later. The next frame starts again from the first leading zero.
- R8: Serial-clock edges while chip select is high leave both enables low. Changes on the sample-word inputs after the chip-select fall do not alter the bits being shifted out.
- R9: A data line whose enable is low reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all other inputs |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host; falling edges advance the frame |
| sampleA | input | 12 | Channel A result, held on the chip-select fall |
| sampleB | input | 12 | Channel B result, held on the chip-select fall |
| doutA | output | 1 | Serial data line A |
| doutB | output | 1 | Serial data line B |
| oeA | output | 1 | Drive enable of line A (low models high impedance) |
| oeB | output | 1 | Drive enable of line B (low models high impedance) |

## Verification
The hardest case to reach is the boundary where the first frame ends and the second begins. Here line B must release while line A continues into the other channel's word. This holds only if chip select is held low through exactly the right number of falls. A second hard case is a serial-clock fall that arrives in the very clk cycle that chip select drops. The stimulus reaches both cases with directed frames of 16, 32 and 40 falls and with a frame whose first fall coincides with chip select. It adds early aborts, sample-word changes in mid-frame and randomly sized frames. A behavioural queue model is compared against the outputs on every cycle.

// File: rtl/adcEmuPkg.sv
package adcEmuPkg;

  // Strobes and enables passed from the control to the datapath.
  typedef struct packed {
    logic capture;  // chip select seen falling: load both frames
    logic advance;  // counted serial-clock fall: shift one bit
    logic abort;    // chip select seen rising: drop the frame
    logic enA;      // line A is being driven
    logic enB;      // line B is being driven
  } ctrlStrobes_t;

endpackage

// File: rtl/adcEmuEdges.sv
module adcEmuEdges (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  output logic csFall,
  output logic csRise,
  output logic sclkFall
);

  logic csPrev;
  logic sclkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclk;
    end
  end

  always_comb begin
    csFall   = csPrev & ~csN;
    csRise   = ~csPrev & csN;
    sclkFall = sclkPrev & ~sclk;
  end

endmodule

// File: rtl/adcEmuCtrl.sv
module adcEmuCtrl
  import adcEmuPkg::*;
#(
  parameter int FRAME_LEN = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         csFall,
  input  logic         csRise,
  input  logic         sclkFall,
  output ctrlStrobes_t strobes
);

  localparam int TOTAL_LEN = 2 * FRAME_LEN;
  localparam int CNT_W     = $clog2(TOTAL_LEN + 1);
  localparam logic [CNT_W-1:0] TOTAL_C = CNT_W'(TOTAL_LEN);
  localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0] fallCnt;
  logic             active;
  logic             doAdvance;

  // A fall in the cycle chip select drops is not counted: active is still low.
  always_comb begin
    doAdvance = active & ~csN & sclkFall & ~csFall & ~csRise & (fallCnt < TOTAL_C);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fallCnt <= '0;
      active  <= 1'b0;
    end else if (csRise) begin
      fallCnt <= '0;
      active  <= 1'b0;
    end else if (csFall) begin
      fallCnt <= '0;
      active  <= 1'b1;
    end else if (doAdvance) begin
      fallCnt <= fallCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobes.capture = csFall;
    strobes.advance = doAdvance;
    strobes.abort   = csRise;
    strobes.enA     = active & (fallCnt < TOTAL_C);
    strobes.enB     = active & (fallCnt < FRAME_C);
  end

endmodule

// File: rtl/adcEmuData.sv
module adcEmuData
  import adcEmuPkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 2,
  parameter int TRAIL_ZEROS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] sampleA,
  input  logic [DATA_W-1:0] sampleB,
  output logic              doutA,
  output logic              doutB
);

  localparam int FRAME_LEN = LEAD_ZEROS + DATA_W + TRAIL_ZEROS;
  localparam int TOTAL_LEN = 2 * FRAME_LEN;

  logic [TOTAL_LEN-1:0] shiftA;
  logic [FRAME_LEN-1:0] shiftB;
  logic [FRAME_LEN-1:0] frameA;
  logic [FRAME_LEN-1:0] frameB;

  always_comb begin
    frameA = {{LEAD_ZEROS{1'b0}}, sampleA, {TRAIL_ZEROS{1'b0}}};
    frameB = {{LEAD_ZEROS{1'b0}}, sampleB, {TRAIL_ZEROS{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.abort) begin
      shiftA <= '0;
      shiftB <= '0;
    end else if (strobes.capture) begin
      shiftA <= {frameA, frameB};
      shiftB <= frameB;
    end else if (strobes.advance) begin
      shiftA <= {shiftA[TOTAL_LEN-2:0], 1'b0};
      shiftB <= {shiftB[FRAME_LEN-2:0], 1'b0};
    end
  end

  always_comb begin
    doutA = strobes.enA & shiftA[TOTAL_LEN-1];
    doutB = strobes.enB & shiftB[FRAME_LEN-1];
  end

endmodule

// File: rtl/adcDualPortEmu.sv
module adcDualPortEmu
  import adcEmuPkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 2,
  parameter int TRAIL_ZEROS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sampleA,
  input  logic [DATA_W-1:0] sampleB,
  output logic              doutA,
  output logic              doutB,
  output logic              oeA,
  output logic              oeB
);

  localparam int FRAME_LEN = LEAD_ZEROS + DATA_W + TRAIL_ZEROS;

  logic         csFall;
  logic         csRise;
  logic         sclkFall;
  ctrlStrobes_t strobes;

  adcEmuEdges edges_i (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sclk     (sclk),
    .csFall   (csFall),
    .csRise   (csRise),
    .sclkFall (sclkFall)
  );

  adcEmuCtrl #(.FRAME_LEN(FRAME_LEN)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .csFall   (csFall),
    .csRise   (csRise),
    .sclkFall (sclkFall),
    .strobes  (strobes)
  );

  adcEmuData #(
    .DATA_W      (DATA_W),
    .LEAD_ZEROS  (LEAD_ZEROS),
    .TRAIL_ZEROS (TRAIL_ZEROS)
  ) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .sampleA (sampleA),
    .sampleB (sampleB),
    .doutA   (doutA),
    .doutB   (doutB)
  );

  always_comb begin
    oeA = strobes.enA;
    oeB = strobes.enB;
  end

endmodule

// File: rtl/adcDualPortEmuChk.sv
module adcDualPortEmuChk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic doutA,
  input logic doutB,
  input logic oeA,
  input logic oeB
);

  AST_FALL_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |=> (oeA && oeB && !doutA && !doutB)); // R2

  AST_B_INSIDE_A: assert property (@(posedge clk) disable iff (!rstN)
    oeB |-> oeA); // R4

  AST_RISE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> (!oeA && !oeB)); // R7

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> (!oeA && !oeB)); // R8

  AST_QUIET_LINE_A: assert property (@(posedge clk) disable iff (!rstN)
    !oeA |-> !doutA); // R9

  AST_QUIET_LINE_B: assert property (@(posedge clk) disable iff (!rstN)
    !oeB |-> !doutB); // R9

endmodule

bind adcDualPortEmu adcDualPortEmuChk chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .csN   (csN),
  .doutA (doutA),
  .doutB (doutB),
  .oeA   (oeA),
  .oeB   (oeB)
);

// File: tb/adcDualPortEmu_tb.sv
`timescale 1ns/1ps
module adcDualPortEmu_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] sampleA = '0;
  logic [11:0] sampleB = '0;
  logic        doutA, doutB, oeA, oeB;

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  string curReq  = "R1";

  always #2.5 clk = ~clk;

  adcDualPortEmu dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .sampleA(sampleA), .sampleB(sampleB),
    .doutA(doutA), .doutB(doutB), .oeA(oeA), .oeB(oeB)
  );

  // Behavioural reference: two bit queues, consumed one bit per counted fall.
  bit mActive = 0;
  bit mCsPrev = 1;
  bit mSclkPrev = 1;
  bit qA[$];
  bit qB[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mCsPrev = 1; mSclkPrev = 1;
      qA.delete(); qB.delete();
    end else begin
      if (!mCsPrev && csN) begin
        mActive = 0; qA.delete(); qB.delete();
      end else if (mCsPrev && !csN) begin
        qA.delete(); qB.delete();
        repeat (2) qA.push_back(1'b0);
        for (int b = 11; b >= 0; b--) qA.push_back(sampleA[b]);
        repeat (4) qA.push_back(1'b0);
        for (int b = 11; b >= 0; b--) qA.push_back(sampleB[b]);
        repeat (2) qA.push_back(1'b0);
        repeat (2) qB.push_back(1'b0);
        for (int b = 11; b >= 0; b--) qB.push_back(sampleB[b]);
        repeat (2) qB.push_back(1'b0);
        mActive = 1;
      end else if (!csN && mActive && mSclkPrev && !sclk) begin
        if (qA.size() > 0) void'(qA.pop_front());
        if (qB.size() > 0) void'(qB.pop_front());
      end
      mCsPrev = csN;
      mSclkPrev = sclk;
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Per-cycle comparison against the model (R9 holds on every cycle).
  always @(negedge clk) begin
    if (rstN) begin
      bit eOeA, eOeB, eA, eB;
      eOeA = mActive && qA.size() > 0;
      eOeB = mActive && qB.size() > 0;
      eA = eOeA ? qA[0] : 1'b0;
      eB = eOeB ? qB[0] : 1'b0;
      check(curReq, "lines vs model (R9 quiet when off)",
            {28'd0, oeA, oeB, doutA, doutB}, {28'd0, eOeA, eOeB, eA, eB});
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs one frame with nFalls serial-clock falls and checks line A bit by bit.
  task automatic runFrame(input int nFalls, input logic [11:0] a, input logic [11:0] b,
                          input bit coincide, input bit changeMid, input string req);
    logic [31:0] expA;
    logic [31:0] gotA;
    int          bad;
    expA = {2'b00, a, 2'b00, 2'b00, b, 2'b00};
    gotA = '0;
    bad = 0;
    curReq = req;
    @(negedge clk);
    sampleA = a; sampleB = b; csN = 1'b0;
    if (coincide) sclk = 1'b0;
    @(negedge clk);
    gotA[31] = doutA;
    check("R2", "enables at frame start", {oeA, oeB}, 2'b11);
    if (coincide) begin
      sclk = 1'b1;
      idle(1);
    end
    for (int i = 1; i <= nFalls; i++) begin
      sclk = 1'b0;
      @(negedge clk);
      if (i <= 31) gotA[31-i] = doutA;
      if (changeMid && i == 3) begin
        sampleA = ~a; sampleB = ~b;
      end
      if (i == 16) check("R4", "line B released after fall 16", {oeA, oeB}, 2'b10);
      if (i == 32) check("R5", "line A released after fall 32", {oeA, oeB}, 2'b00);
      sclk = 1'b1;
      @(negedge clk);
    end
    for (int i = 0; i <= 31 && i <= nFalls; i++)
      if (gotA[31-i] != expA[31-i]) bad++;
    check(req, "line A bit sequence mismatches", bad, 0);
    csN = 1'b1;
    @(negedge clk);
    check("R7", "released after chip select rise", {oeA, oeB, doutA, doutB}, 4'b0000);
  endtask

  initial begin
    idle(3);
    check("R1", "outputs during reset", {oeA, oeB, doutA, doutB}, 4'b0000);
    rstN = 1'b1;
    idle(3);
    check("R1", "outputs after reset", {oeA, oeB, doutA, doutB}, 4'b0000);

    runFrame(16, 12'hA5C, 12'h3E1, 0, 0, "R3");
    runFrame(16, 12'hFFF, 12'hFFF, 0, 0, "R4");
    runFrame(32, 12'h812, 12'hC07, 0, 0, "R5");
    runFrame(40, 12'h001, 12'h800, 0, 0, "R5");
    runFrame(16, 12'h9B3, 12'h4D2, 1, 0, "R6");
    runFrame(7,  12'hFFF, 12'hFFF, 0, 0, "R7");
    runFrame(20, 12'h5A5, 12'hA5A, 0, 1, "R8");

    curReq = "R8";
    for (int k = 0; k < 6; k++) begin
      sclk = 1'b0; idle(2);
      sclk = 1'b1; idle(2);
      sampleA = 12'(k * 37); sampleB = 12'(k * 91);
    end
    check("R8", "clocking with chip select high", {oeA, oeB, doutA, doutB}, 4'b0000);
    runFrame(2, 12'h7C3, 12'h1F0, 0, 0, "R7");

    for (int f = 0; f < 24; f++)
      runFrame(int'($urandom_range(0, 36)), 12'($urandom), 12'($urandom),
               bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), "R3");

    idle(4);
    summary();
    $finish;
  end

endmodule